// File: doc/BRIEF.md
# Trace Power-Down Status Register

This block is a single read-only status word that an external debugger reads over a small memory-mapped bus with a request/ready/response handshake. The word reports three things. It shows whether the trace core power domain is up. It holds a sticky flag that records that trace register state may have been lost because core power was removed. It also shows the live state of the processor OS Lock. The block lives in the always-on domain. It resynchronises the core-powered indication and turns a falling edge of that indication into a loss event, which sets the sticky flag.

A read of the register returns the flag and then clears it. The debugger uses this to tell whether the trace configuration survived since it last looked. While the core domain is down, every access ends in an error response. A write to the register offset is accepted and ignored. An access to any other offset is refused with an error.

Control is a two-state machine. In `TRPS_IDLE` the block is ready, and the transition ACCEPT moves it to `TRPS_RESP` when a request is present. In `TRPS_RESP` the response is presented for exactly one cycle, and the transition RETURN takes it back to `TRPS_IDLE` unconditionally. With no request, `TRPS_IDLE` holds.

Top module: `trps_status_top`

## Requirements
- R1: After reset the flag reads 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read of offset 0x314 while powered returns `rsp_err`=0. The data has bit 0 = 1, bit 1 = flag, bit 5 = OS Lock, and every other bit 0.
- R3: A successful read returns the flag value from before the read and leaves the flag at 0 afterwards.
- R4: A falling edge of the synchronised core-powered input sets the flag to 1.
- R5: While the gate sees the domain unpowered, any access returns `rsp_err`=1 with data 0. The flag is left unchanged.
- R6: A powered write to offset 0x314 returns `rsp_err`=0 with data 0 and changes no state.
- R7: An access to any offset other than 0x314 returns `rsp_err`=1 with data 0 and leaves the flag unchanged.
- R8: When a loss event and a read-clear fall on the same edge, the flag ends at 1. That read still returns the old flag value with an OK response.
- R9: Bit 5 of a read reflects `oslock_in` as sampled at the acceptance edge: 1 means locked, 0 means unlocked. The OS Lock never blocks an access.
- R10: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. The response is valid for exactly the following cycle, and `req_ready` is 0 during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low trace unit reset |
| core_pwr_async | input | 1 | Core domain powered indication, asynchronous |
| oslock_in | input | 1 | Processor OS Lock state, 1 = locked |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |

## Verification
A read-clear and a power-loss event can land on the same clock edge. This happens because the access gate watches power one flop later than the edge detector. The bench drops the power input, waits two edges, and then issues a read that is accepted exactly on the edge where the loss is registered. It expects an OK response carrying the old cleared flag, and a later read must show the flag at 1. That later read proves that the set won over the clear.

// File: rtl/trps_pkg.sv
package trps_pkg;
    localparam int DATA_W     = 32;
    localparam int BIT_POWER  = 0;
    localparam int BIT_STICKY = 1;
    localparam int BIT_OSLK   = 5;

    typedef enum logic [0:0] {
        TRPS_IDLE = 1'b0,
        TRPS_RESP = 1'b1
    } trps_state_e;
endpackage

// File: rtl/trps_pwr_sync.sv
module trps_pwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_async,
    output logic pwr_gate,
    output logic loss_evt
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              gate_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pwr_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pwr_async};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= chain_q[LAST];
    end

    assign pwr_gate = gate_q;
    assign loss_evt = gate_q & ~chain_q[LAST];

    // R4: a loss event removes power from the gate on the next edge
    assert_loss_drops_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loss_evt |=> !pwr_gate);
endmodule

// File: rtl/trps_sticky.sv
module trps_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic sticky
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b1;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assign sticky = flag_q;

    assert_loss_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> sticky);
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !sticky);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && set_evt) |=> sticky);
    assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !set_evt) |=> $stable(sticky));
endmodule

// File: rtl/trps_decode.sv
module trps_decode
    import trps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h314
) (
    input  logic              pwr_up,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sticky,
    input  logic              oslock,
    output logic              resp_err,
    output logic              read_ok,
    output logic [DATA_W-1:0] resp_word
);
    logic hit;

    always_comb begin
        hit       = (addr == REG_OFFSET);
        resp_err  = !(hit && pwr_up);
        read_ok   = hit && pwr_up && !is_write;
        resp_word = '0;
        if (read_ok) begin
            resp_word[BIT_POWER]  = 1'b1;
            resp_word[BIT_STICKY] = sticky;
            resp_word[BIT_OSLK]   = oslock;
        end
    end

    // R5 / R7: refused accesses never carry data
    always_comb begin
        assert_err_no_data_R7: assert (!(resp_err && (resp_word != '0)));
    end
endmodule

// File: rtl/trps_status_top.sv
module trps_status_top
    import trps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h314,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_pwr_async,
    input  logic              oslock_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    trps_state_e state_q, state_d;

    logic              pwr_gate;
    logic              loss_evt;
    logic              sticky;
    logic              dec_err;
    logic              dec_read_ok;
    logic [DATA_W-1:0] dec_word;
    logic              accept;
    logic              err_q;
    logic [DATA_W-1:0] data_q;

    trps_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_async (core_pwr_async),
        .pwr_gate  (pwr_gate),
        .loss_evt  (loss_evt)
    );

    trps_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
        .pwr_up    (pwr_gate),
        .is_write  (req_write),
        .addr      (req_addr),
        .sticky    (sticky),
        .oslock    (oslock_in),
        .resp_err  (dec_err),
        .read_ok   (dec_read_ok),
        .resp_word (dec_word)
    );

    trps_sticky u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (loss_evt),
        .clr_req (accept && dec_read_ok),
        .sticky  (sticky)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRPS_IDLE;
        else        state_q <= state_d;
    end

    // next state: ACCEPT, RETURN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRPS_IDLE: if (req_valid) state_d = TRPS_RESP;
            TRPS_RESP: state_d = TRPS_IDLE;
            default:   state_d = TRPS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            TRPS_IDLE: req_ready = 1'b1;
            TRPS_RESP: rsp_valid = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            err_q  <= dec_err;
            data_q <= dec_word;
        end
    end

    assign rsp_err   = rsp_valid & err_q;
    assign rsp_rdata = rsp_valid ? data_q : '0;

    assert_accept_gives_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
    assert_resp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    assert_unpowered_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pwr_gate) |=> (rsp_valid && rsp_err && rsp_rdata == '0));
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (rsp_rdata[31:6] == '0 && rsp_rdata[4:2] == '0));
endmodule

// File: tb/sim_trps_status_top.sv
`timescale 1ns/1ps
module sim_trps_status_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_pwr_async = 1'b0;
    logic        oslock_in = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int compared = 0;
    int mismatched = 0;
    logic model_flag = 1'b1;
    logic model_pwr = 1'b0;

    always #2.5 clk = ~clk;

    trps_status_top u0 (
        .clk(clk), .rst_n(rst_n), .core_pwr_async(core_pwr_async),
        .oslock_in(oslock_in), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a,
                          output logic err, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 valid", {30'b0, rsp_valid, req_ready}, 32'h2);
        err = rsp_err;
        d   = rsp_rdata;
        @(posedge clk);
    endtask

    task automatic set_power(input logic v);
        @(negedge clk);
        core_pwr_async = v;
        if (model_pwr && !v) model_flag = 1'b1;
        model_pwr = v;
        repeat (5) @(posedge clk);
    endtask

    function automatic logic [11:0] addr_of(input int i);
        case (i)
            0: return 12'h314;
            1: return 12'h310;
            2: return 12'h315;
            3: return 12'h000;
            4: return 12'hB14;
            default: return 12'hFFF;
        endcase
    endfunction

    task automatic sweep_one(input logic wr, input logic [11:0] a);
        logic e; logic [31:0] d;
        logic ok;
        logic [31:0] exp_d;
        string tag;
        ok    = model_pwr && (a == 12'h314);
        exp_d = 32'h0;
        if (!model_pwr)   tag = "R5";
        else if (!ok)     tag = "R7";
        else if (wr)      tag = "R6";
        else              tag = "R2/R9";
        if (ok && !wr) exp_d = {26'b0, oslock_in, 3'b0, model_flag, 1'b1};
        access(wr, a, e, d);
        check({tag, " err"}, {31'b0, e}, {31'b0, !ok});
        check({tag, " data"}, d, exp_d);
        if (ok && !wr) model_flag = 1'b0;
    endtask

    initial begin
        #500000;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic e; logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", {30'b0, req_ready, rsp_valid}, 32'h2);

        core_pwr_async = 1'b1; model_pwr = 1'b1;
        repeat (5) @(posedge clk);
        // R1 / R3: reset value then cleared by the read
        access(1'b0, 12'h314, e, d);
        check("R1 flag", d, 32'h3);
        access(1'b0, 12'h314, e, d);
        check("R3 cleared", d, 32'h1);
        model_flag = 1'b0;

        // sweep over OS Lock, direction, offset, with flag both set and clear
        for (int rep = 0; rep < 2; rep++) begin
            if (rep == 1) begin set_power(1'b0); set_power(1'b1); end
            for (int ol = 0; ol < 2; ol++) begin
                oslock_in = ol[0];
                for (int wr = 0; wr < 2; wr++)
                    for (int ai = 0; ai < 6; ai++)
                        sweep_one(wr[0], addr_of(ai));
            end
        end

        // R4: loss sets the flag
        set_power(1'b0);
        // R5: unpowered sweep, flag must survive error reads
        for (int wr = 0; wr < 2; wr++)
            for (int ai = 0; ai < 6; ai++)
                sweep_one(wr[0], addr_of(ai));
        set_power(1'b1);
        oslock_in = 1'b0;
        access(1'b0, 12'h314, e, d);
        check("R4/R5 flag kept", d, 32'h3);

        // R8: read accepted on the edge that registers the loss
        oslock_in = 1'b1;
        @(negedge clk);
        core_pwr_async = 1'b0;
        @(posedge clk);
        @(posedge clk);
        access(1'b0, 12'h314, e, d);
        check("R8 collide err", {31'b0, e}, 32'h0);
        check("R8 collide data", d, 32'h21);
        core_pwr_async = 1'b1;
        repeat (5) @(posedge clk);
        access(1'b0, 12'h314, e, d);
        check("R8 set wins", d, 32'h23);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule